// File: doc/BRIEF.md
# Replicated Register Access Sequencer

This block sits on the initiator side of a register bus. It takes read and write requests aimed at registers that exist as several copies behind one address. Each request becomes the right series of single bus transactions. Before the request is accepted, the address is compared against per-type address range tables, which have to be loaded first. The lowest-numbered type that matches supplies the group and instance used to pick one copy. The highest type is the direct-access type: a request that matches only that type goes straight to the target with no steering.

A steered request first polls a shared semaphore register until it reads 1. Next it writes the steering selector, then performs the access. After a unicast write it puts the selector back into multicast mode, and last it releases the semaphore by writing 1 to it. A multicast write takes the semaphore but leaves the selector alone. The group and instance targets come in as configuration inputs. The semaphore timeout is derived from the clock frequency in MHz and a time in microseconds.

Top module: `repl_access_seq`

## Requirements
- R1: A range table entry matches when it is enabled and start <= address <= end, both ends included. A steered access uses the group and instance inputs of the matching type. An entry loaded with its enable clear never matches.
- R2: When ranges of several types match, the type with the lowest index wins.
- R3: An address that matches only the last type (NT-1, direct access) makes exactly one bus transaction straight to the target, with no semaphore and no selector write. The warning flag stays at 0.
- R4: An address that matches no enabled range is steered to group 0 and instance 0, and rsp_warn is 1 in its response. Otherwise rsp_warn is 0.
- R5: The semaphore is taken by repeated reads of SEM_ADDR until one returns the value 1. Any other value causes another read.
- R6: The semaphore is abandoned once the polling has lasted CLK_MHZ*SEM_US cycles and a poll read still returns a value other than 1. The access then goes ahead, and the response carries rsp_timeout=1. Otherwise rsp_timeout is 0.
- R7: Request kind 0 is a read. The selector at SEL_ADDR is written with bit DW-1 (multicast) set, the group in bits [IW+GW-1:IW] and the instance in bits [IW-1:0]. The target is then read, and its data is returned in rsp_rdata.
- R8: Request kind 1 is a unicast write. The selector is written with bit DW-1 clear, then the target is written with the request data. The selector is then written again with only bit DW-1 set.
- R9: Request kind 2 is a multicast write. After the semaphore is taken, the target is written directly, with no selector write.
- R10: Every steered request ends its bus activity with a write of the value 1 to SEM_ADDR.
- R11: req_ready is high only when no request is in progress. Each accepted request produces exactly one single-cycle rsp_valid pulse.
- R12: After reset, req_ready is 1, and rsp_valid and bus_req are 0.
- R13: A bus transaction completes on a cycle where bus_req and bus_ack are both high. Until then, bus_req, bus_we, bus_addr and bus_wdata hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load one range table entry |
| cfg_type | input | TW | Type of the entry being loaded |
| cfg_slot | input | SW | Slot of the entry within its type |
| cfg_lo | input | AW | First address of the range |
| cfg_hi | input | AW | Last address of the range |
| cfg_en | input | 1 | Enable of the loaded entry |
| tgt_group | input | NT*GW | Group target for each type |
| tgt_inst | input | NT*IW | Instance target for each type |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_kind | input | 2 | 0 read, 1 unicast write, 2 multicast write |
| req_addr | input | AW | Target register address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Single-cycle completion strobe |
| rsp_rdata | output | DW | Read data |
| rsp_warn | output | 1 | Address matched no range |
| rsp_timeout | output | 1 | Semaphore poll timed out |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | Bus write when high |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_ack | input | 1 | Bus transaction complete |
| bus_rdata | input | DW | Bus read data, valid with bus_ack |

## Verification
A wrong lookup or a wrong sequencer state shows up on the bus within the same request. Such a fault can steer to the wrong group or instance, or it can skip or add a selector write, a restore or a release. Each request is therefore checked transaction by transaction against a list of expected transactions built from the address ranges and the request kind. The sweep covers every range edge, the overlaps between types and a disabled entry, with 0 to 2 denied polls. A broken timer is visible in how many cycles the response takes and in the timeout flag.

// File: rtl/repl_seq_pkg.sv
package repl_seq_pkg;

  typedef enum logic [1:0] {
    KIND_READ = 2'd0,
    KIND_UWR  = 2'd1,
    KIND_MWR  = 2'd2,
    KIND_RSV  = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEM,
    ST_SEL,
    ST_ACC,
    ST_RESTORE,
    ST_REL,
    ST_DIRECT,
    ST_RSP
  } seq_state_e;

endpackage

// File: rtl/range_table.sv
module range_table #(
  parameter int NT = 4,
  parameter int NE = 8,
  parameter int AW = 24,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1,
  localparam int SW = (NE > 1) ? $clog2(NE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [TW-1:0] cfg_type,
  input  logic [SW-1:0] cfg_slot,
  input  logic [AW-1:0] cfg_lo,
  input  logic [AW-1:0] cfg_hi,
  input  logic          cfg_en,
  input  logic [AW-1:0] look_addr,
  output logic [NT-1:0] type_hit
);

  for (genvar t = 0; t < NT; t++) begin : g_type
    logic [NE-1:0] ent_hit;
    for (genvar e = 0; e < NE; e++) begin : g_ent
      logic [AW-1:0] lo_q, hi_q;
      logic          en_q;
      logic          wr_en;
      assign wr_en = cfg_we && (cfg_type == TW'(t)) && (cfg_slot == SW'(e));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lo_q <= '0;
          hi_q <= '0;
          en_q <= 1'b0;
        end else if (wr_en) begin
          lo_q <= cfg_lo;
          hi_q <= cfg_hi;
          en_q <= cfg_en;
        end
      end
      assign ent_hit[e] = en_q && (look_addr >= lo_q) && (look_addr <= hi_q);
    end
    assign type_hit[t] = |ent_hit;
  end

endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int NT = 4,
  parameter int GW = 4,
  parameter int IW = 4
) (
  input  logic [NT-1:0]    type_hit,
  input  logic [NT*GW-1:0] tgt_group,
  input  logic [NT*IW-1:0] tgt_inst,
  output logic             is_direct,
  output logic             no_match,
  output logic [GW-1:0]    pick_group,
  output logic [IW-1:0]    pick_inst
);

  logic any_steered;

  always_comb begin
    any_steered = 1'b0;
    pick_group  = '0;
    pick_inst   = '0;
    // walk from high to low so the lowest matching type is assigned last
    for (int t = NT - 2; t >= 0; t--) begin
      if (type_hit[t]) begin
        any_steered = 1'b1;
        pick_group  = tgt_group[t*GW +: GW];
        pick_inst   = tgt_inst[t*IW +: IW];
      end
    end
    is_direct = type_hit[NT-1] && !any_steered;
    no_match  = ~|type_hit;
  end

endmodule

// File: rtl/sem_timer.sv
module sem_timer #(
  parameter int CLK_MHZ = 200,
  parameter int SEM_US  = 10,
  localparam int LIMIT = CLK_MHZ * SEM_US,
  localparam int CW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = (cnt_q == CW'(LIMIT));
  assign cnt_en  = clr || (run && !expired);

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import repl_seq_pkg::*;
#(
  parameter int AW       = 24,
  parameter int DW       = 32,
  parameter int GW       = 4,
  parameter int IW       = 4,
  parameter int CLK_MHZ  = 200,
  parameter int SEM_US   = 10,
  parameter logic [AW-1:0] SEM_ADDR = 24'h000FD0,
  parameter logic [AW-1:0] SEL_ADDR = 24'h000FDC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          look_direct,
  input  logic          look_none,
  input  logic [GW-1:0] look_group,
  input  logic [IW-1:0] look_inst,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_warn,
  output logic          rsp_timeout,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata
);

  seq_state_e    st_q, st_d;
  req_kind_e     kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic [GW-1:0] grp_q;
  logic [IW-1:0] inst_q;
  logic          warn_q, to_q;

  logic accept, is_rd, sem_granted, sem_expired, to_set, rd_cap, done;
  logic [DW-1:0] sel_val, mc_only;

  assign accept      = req_valid && (st_q == ST_IDLE);
  assign is_rd       = (kind_q != KIND_UWR) && (kind_q != KIND_MWR);
  assign done        = bus_req && bus_ack;
  assign sem_granted = (bus_rdata == DW'(1));

  sem_timer #(.CLK_MHZ(CLK_MHZ), .SEM_US(SEM_US)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept),
    .run     (st_q == ST_SEM),
    .expired (sem_expired)
  );

  always_comb begin
    mc_only         = '0;
    mc_only[DW-1]   = 1'b1;
    sel_val         = '0;
    sel_val[DW-1]   = is_rd;
    sel_val[IW +: GW] = grp_q;
    sel_val[IW-1:0] = inst_q;
  end

  // next-state process
  always_comb begin
    st_d   = st_q;
    to_set = 1'b0;
    rd_cap = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = look_direct ? ST_DIRECT : ST_SEM;
      ST_SEM: if (done) begin
        if (sem_granted || sem_expired) begin
          to_set = !sem_granted;
          st_d   = (kind_q == KIND_MWR) ? ST_ACC : ST_SEL;
        end
      end
      ST_SEL: if (done) st_d = ST_ACC;
      ST_ACC: if (done) begin
        rd_cap = is_rd;
        st_d   = (kind_q == KIND_UWR) ? ST_RESTORE : ST_REL;
      end
      ST_RESTORE: if (done) st_d = ST_REL;
      ST_REL:     if (done) st_d = ST_RSP;
      ST_DIRECT: if (done) begin
        rd_cap = is_rd;
        st_d   = ST_RSP;
      end
      ST_RSP:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      kind_q  <= KIND_READ;
      addr_q  <= '0;
      wdata_q <= '0;
      grp_q   <= '0;
      inst_q  <= '0;
      warn_q  <= 1'b0;
      to_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        kind_q  <= req_kind_e'(req_kind);
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        grp_q   <= look_none ? '0 : look_group;
        inst_q  <= look_none ? '0 : look_inst;
        warn_q  <= look_none;
        to_q    <= 1'b0;
        rdata_q <= '0;
      end
      if (to_set) to_q <= 1'b1;
      if (rd_cap) rdata_q <= bus_rdata;
    end
  end

  // bus drive
  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = addr_q;
    bus_wdata = wdata_q;
    unique case (st_q)
      ST_SEM: begin
        bus_req = 1'b1; bus_addr = SEM_ADDR; bus_wdata = '0;
      end
      ST_SEL: begin
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = SEL_ADDR; bus_wdata = sel_val;
      end
      ST_RESTORE: begin
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = SEL_ADDR; bus_wdata = mc_only;
      end
      ST_REL: begin
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = SEM_ADDR; bus_wdata = DW'(1);
      end
      ST_ACC, ST_DIRECT: begin
        bus_req = 1'b1; bus_we = !is_rd;
      end
      default: ;
    endcase
  end

  assign req_ready   = (st_q == ST_IDLE);
  assign rsp_valid   = (st_q == ST_RSP);
  assign rsp_rdata   = rdata_q;
  assign rsp_warn    = rsp_valid && warn_q;
  assign rsp_timeout = rsp_valid && to_q;

endmodule

// File: rtl/repl_access_seq.sv
module repl_access_seq #(
  parameter int NT       = 4,
  parameter int NE       = 8,
  parameter int AW       = 24,
  parameter int DW       = 32,
  parameter int GW       = 4,
  parameter int IW       = 4,
  parameter int CLK_MHZ  = 200,
  parameter int SEM_US   = 10,
  parameter logic [AW-1:0] SEM_ADDR = 24'h000FD0,
  parameter logic [AW-1:0] SEL_ADDR = 24'h000FDC,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1,
  localparam int SW = (NE > 1) ? $clog2(NE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [TW-1:0]    cfg_type,
  input  logic [SW-1:0]    cfg_slot,
  input  logic [AW-1:0]    cfg_lo,
  input  logic [AW-1:0]    cfg_hi,
  input  logic             cfg_en,
  input  logic [NT*GW-1:0] tgt_group,
  input  logic [NT*IW-1:0] tgt_inst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic             rsp_warn,
  output logic             rsp_timeout,
  output logic             bus_req,
  output logic             bus_we,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic             bus_ack,
  input  logic [DW-1:0]    bus_rdata
);

  logic [NT-1:0] type_hit;
  logic          look_direct, look_none;
  logic [GW-1:0] look_group;
  logic [IW-1:0] look_inst;

  range_table #(.NT(NT), .NE(NE), .AW(AW)) table_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_type  (cfg_type),
    .cfg_slot  (cfg_slot),
    .cfg_lo    (cfg_lo),
    .cfg_hi    (cfg_hi),
    .cfg_en    (cfg_en),
    .look_addr (req_addr),
    .type_hit  (type_hit)
  );

  prio_pick #(.NT(NT), .GW(GW), .IW(IW)) pick_i (
    .type_hit   (type_hit),
    .tgt_group  (tgt_group),
    .tgt_inst   (tgt_inst),
    .is_direct  (look_direct),
    .no_match   (look_none),
    .pick_group (look_group),
    .pick_inst  (look_inst)
  );

  seq_fsm #(
    .AW(AW), .DW(DW), .GW(GW), .IW(IW), .CLK_MHZ(CLK_MHZ), .SEM_US(SEM_US),
    .SEM_ADDR(SEM_ADDR), .SEL_ADDR(SEL_ADDR)
  ) fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_kind    (req_kind),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .look_direct (look_direct),
    .look_none   (look_none),
    .look_group  (look_group),
    .look_inst   (look_inst),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .rsp_warn    (rsp_warn),
    .rsp_timeout (rsp_timeout),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_ack     (bus_ack),
    .bus_rdata   (bus_rdata)
  );

endmodule

// File: rtl/repl_access_seq_chk.sv
module repl_access_seq_chk #(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_warn,
  input logic          rsp_timeout,
  input logic          bus_req,
  input logic          bus_ack,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata
);

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R11

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R11

  AST_NO_RSP_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R11

  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_req); // R12

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr)
      && $stable(bus_wdata)); // R13

  AST_WARN_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_warn |-> rsp_valid); // R4

  AST_TIMEOUT_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_timeout |-> rsp_valid); // R6

endmodule

bind repl_access_seq repl_access_seq_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_warn    (rsp_warn),
  .rsp_timeout (rsp_timeout),
  .bus_req     (bus_req),
  .bus_ack     (bus_ack),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata)
);

// File: tb/repl_access_seq_tb_top.sv
`timescale 1ns/1ps
module repl_access_seq_tb_top;

  localparam int NT = 4, NE = 8, AW = 24, DW = 32, GW = 4, IW = 4;
  localparam logic [AW-1:0] SEM = 24'h000FD0;
  localparam logic [AW-1:0] SEL = 24'h000FDC;
  localparam int TMO_CYC = 200 * 10;
  localparam int LOGN = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_type = '0;
  logic [2:0]    cfg_slot = '0;
  logic [AW-1:0] cfg_lo = '0, cfg_hi = '0;
  logic          cfg_en = 1'b0;
  logic [NT*GW-1:0] tgt_group = {4'd9, 4'd5, 4'd3, 4'd1};
  logic [NT*IW-1:0] tgt_inst  = {4'd9, 4'd7, 4'd0, 4'd2};
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_kind = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid, rsp_warn, rsp_timeout;
  logic [DW-1:0] rsp_rdata;
  logic          bus_req, bus_we, bus_ack;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  repl_access_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_type(cfg_type), .cfg_slot(cfg_slot),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_en(cfg_en), .tgt_group(tgt_group),
    .tgt_inst(tgt_inst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_warn(rsp_warn),
    .rsp_timeout(rsp_timeout), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata)
  );

  // ---------------- bus responder and transaction log ----------------
  logic          lg_we   [LOGN];
  logic [AW-1:0] lg_addr [LOGN];
  logic [DW-1:0] lg_wd   [LOGN];
  int lg_n, sem_rd_total, sem_base, deny_n;
  logic          last_we;
  logic [AW-1:0] last_addr;
  logic [DW-1:0] last_wd;

  initial begin
    sem_base = 0;
    deny_n   = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ack      <= 1'b0;
      bus_rdata    <= '0;
      lg_n         <= 0;
      sem_rd_total <= 0;
    end else begin
      if (bus_req && bus_ack) begin
        if (lg_n < LOGN) begin
          lg_we[lg_n]   <= bus_we;
          lg_addr[lg_n] <= bus_addr;
          lg_wd[lg_n]   <= bus_wdata;
        end
        last_we   <= bus_we;
        last_addr <= bus_addr;
        last_wd   <= bus_wdata;
        lg_n <= lg_n + 1;
        if (!bus_we && bus_addr == SEM) sem_rd_total <= sem_rd_total + 1;
      end
      if (bus_req && !bus_ack) begin
        bus_ack <= 1'b1;
        if (bus_addr == SEM)
          bus_rdata <= ((sem_rd_total - sem_base) >= deny_n) ? 32'd1 : 32'd0;
        else
          bus_rdata <= 32'h5A00_0000 | DW'(bus_addr);
      end else begin
        bus_ack <= 1'b0;
      end
    end
  end

  // ---------------- scoreboard ----------------
  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // model of the range tables
  logic [AW-1:0] m_lo [NT][NE];
  logic [AW-1:0] m_hi [NT][NE];
  logic          m_en [NT][NE];

  task automatic load(input int t, input int s, input logic [AW-1:0] lo,
                      input logic [AW-1:0] hi, input bit en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_type = 2'(t); cfg_slot = 3'(s);
    cfg_lo = lo; cfg_hi = hi; cfg_en = en;
    m_lo[t][s] = lo; m_hi[t][s] = hi; m_en[t][s] = en;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int exp_type(input logic [AW-1:0] a);
    for (int t = 0; t < NT; t++)
      for (int e = 0; e < NE; e++)
        if (m_en[t][e] && a >= m_lo[t][e] && a <= m_hi[t][e]) return t;
    return NT;
  endfunction

  logic          e_we   [16];
  logic [AW-1:0] e_addr [16];
  logic [DW-1:0] e_wd   [16];
  string         e_tag  [16];
  int            e_n;

  task automatic push(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input string tag);
    e_we[e_n] = we; e_addr[e_n] = a; e_wd[e_n] = d; e_tag[e_n] = tag;
    e_n++;
  endtask

  logic [DW-1:0] r_rdata;
  bit            r_warn, r_to;
  int            r_cyc, r_base;

  task automatic issue(input int kind, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input int deny);
    @(negedge clk);
    r_base   = lg_n;
    sem_base = sem_rd_total;
    deny_n   = deny;
    req_valid = 1'b1; req_kind = 2'(kind); req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11 busy", 32'(req_ready), 0);
    r_cyc = 1;
    while (!rsp_valid) begin
      @(negedge clk);
      r_cyc++;
    end
    r_rdata = rsp_rdata; r_warn = rsp_warn; r_to = rsp_timeout;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 single pulse", 32'(rsp_valid), 0);
  endtask

  task automatic run_one(input int kind, input logic [AW-1:0] a, input int deny);
    int t;
    logic [GW-1:0] g;
    logic [IW-1:0] i;
    logic [DW-1:0] sel, d;
    string ttag;
    t = exp_type(a);
    d = 32'hC000_0000 | DW'(a) | (DW'(kind) << 24);
    e_n = 0;
    g = (t < NT - 1) ? tgt_group[t*GW +: GW] : '0;
    i = (t < NT - 1) ? tgt_inst[t*IW +: IW] : '0;
    ttag = (t == NT) ? "R4" : "R1/R2";
    if (t == NT - 1) begin
      push(kind != 0, a, d, "R3 direct");
    end else begin
      for (int p = 0; p <= deny; p++) push(1'b0, SEM, '0, "R5 poll");
      if (kind != 2) begin
        sel = (kind == 0) ? 32'h8000_0000 : 32'h0;
        sel = sel | (DW'(g) << IW) | DW'(i);
        push(1'b1, SEL, sel, (kind == 0) ? {ttag, " R7 sel"} : {ttag, " R8 sel"});
      end
      push(kind != 0, a, d, (kind == 2) ? "R9 access" : "R7/R8 access");
      if (kind == 1) push(1'b1, SEL, 32'h8000_0000, "R8 restore");
      push(1'b1, SEM, 32'd1, "R10 release");
    end
    issue(kind, a, d, deny);
    chk(lg_n - r_base == e_n, {e_tag[e_n-1], " txn count"}, 32'(lg_n - r_base), 32'(e_n));
    if (lg_n - r_base == e_n) begin
      for (int k = 0; k < e_n; k++) begin
        chk(lg_we[r_base+k] == e_we[k], {e_tag[k], " we"}, 32'(lg_we[r_base+k]), 32'(e_we[k]));
        chk(lg_addr[r_base+k] == e_addr[k], {e_tag[k], " addr"},
            32'(lg_addr[r_base+k]), 32'(e_addr[k]));
        if (e_we[k])
          chk(lg_wd[r_base+k] == e_wd[k], {e_tag[k], " wdata"}, lg_wd[r_base+k], e_wd[k]);
      end
    end
    chk(r_warn == (t == NT), "R4 warn", 32'(r_warn), 32'(t == NT));
    chk(r_to == 1'b0, "R6 no timeout", 32'(r_to), 0);
    if (kind == 0)
      chk(r_rdata == (32'h5A00_0000 | DW'(a)), "R7 rdata", r_rdata, 32'h5A00_0000 | DW'(a));
  endtask

  logic [AW-1:0] addrs [23] = '{
    24'h7FFF, 24'h8000, 24'h80FF, 24'h8100, 24'h81FF, 24'h8200, 24'h9000,
    24'hB0FF, 24'hB100, 24'hB3FF, 24'hB400, 24'hD000, 24'hD0FF, 24'hD100,
    24'hE000, 24'hE0FF, 24'hE100, 24'hE1FF, 24'hE200, 24'h0FFF, 24'h1000,
    24'h1FFF, 24'h2000 };

  initial begin
    for (int t = 0; t < NT; t++)
      for (int e = 0; e < NE; e++) begin
        m_lo[t][e] = '0; m_hi[t][e] = '0; m_en[t][e] = 1'b0;
      end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R12 ready", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R12 rsp_valid", 32'(rsp_valid), 0);
    chk(bus_req == 1'b0, "R12 bus_req", 32'(bus_req), 0);

    load(0, 0, 24'h8000, 24'h80FF, 1'b1);
    load(0, 3, 24'hB100, 24'hB3FF, 1'b1);
    load(1, 1, 24'h8080, 24'h81FF, 1'b1);
    load(1, 7, 24'hD000, 24'hD0FF, 1'b1);
    load(1, 2, 24'h9000, 24'h90FF, 1'b0);
    load(2, 0, 24'hE000, 24'hE0FF, 1'b1);
    load(3, 5, 24'h1000, 24'h1FFF, 1'b1);
    load(3, 6, 24'hE080, 24'hE1FF, 1'b1);

    for (int n = 0; n < 23; n++)
      for (int k = 0; k < 3; k++)
        run_one(k, addrs[n], (n + k) % 3);

    // semaphore never granted
    issue(0, 24'h8010, '0, 1 << 30);
    chk(r_to == 1'b1, "R6 timeout flag", 32'(r_to), 1);
    chk(r_cyc >= TMO_CYC && r_cyc < TMO_CYC + 20, "R6 timeout cycles", 32'(r_cyc),
        32'(TMO_CYC));
    chk(last_we && last_addr == SEM && last_wd == 32'd1, "R10 release after timeout",
        32'(last_addr), 32'(SEM));
    chk(r_rdata == (32'h5A00_0000 | 32'h8010), "R6 access proceeds", r_rdata,
        32'h5A00_8010);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule